// File: doc/BRIEF.md
# Quadrature-Phase Fetch/Execute Sequencer

This block divides its input clock into four non-overlapping phase enables, one per input clock period, rotating through Q1, Q2, Q3 and Q4. One rotation is one instruction cycle. The phase enables drive a two-stage pipeline. In one instruction cycle the block fetches a word, and in the next cycle it presents that word to execute while the following word is being fetched. The program counter is told to advance in Q1. The fetched word is captured into the instruction register at the end of Q4.

When execute reports that the instruction it is running changes the program counter, the word already prefetched is no longer valid. For the whole following instruction cycle the block marks a flush. It drops execute-valid and presents a no-operation word in place of the discarded one. A PC-changing instruction therefore takes two instruction cycles. The program memory, the PC register and the ALU sit outside this block.

Top module: `qseq_top`

## Requirements
- R1: While `rst_n_i` is low, and until internal reset release, all four phase enables, `pc_inc_o`, `ir_load_o`, `exec_valid_o` and `flush_o` are low, and `exec_word_o` equals the no-operation word (default 16'h0000).
- R2: Internal reset releases on the second rising clock edge that samples `rst_n_i` high. The first period after that edge shows Q1 (`q_en_o` = 4'b0001).
- R3: Outside reset, exactly one phase enable is high in every clock period. The enables repeat in the order Q1, Q2, Q3, Q4, with bit 0 = Q1 and bit 3 = Q4.
- R4: `pc_inc_o` is high exactly in Q1 periods.
- R5: `ir_load_o` is high exactly in Q4 periods. The value on `instr_i` at the rising edge that ends Q4 is captured as the fetched word.
- R6: A word captured at the end of Q4 appears on `exec_word_o`, with `exec_valid_o` high, for all four periods of the next instruction cycle, unless that cycle is flushed.
- R7: After reset, `exec_valid_o` stays low until the first fetched word has been captured.
- R8: If `pc_chg_i` is high at the rising edge ending Q4 while `exec_valid_o` is high, then in the next instruction cycle `flush_o` is high and `exec_valid_o` is low for all four periods, and `exec_word_o` shows the no-operation word.
- R9: `pc_chg_i` has no effect when it is high only in Q1, Q2 or Q3, or while `exec_valid_o` is low (during a flush cycle, or before the first capture).
- R10: In the cycle after a flush, the word captured at the end of the flush cycle executes normally. A PC-changing instruction thus occupies exactly two instruction cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock, four periods per instruction cycle |
| rst_n_i | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| instr_i | input | IW (16) | Word returned by program memory for the current fetch |
| pc_chg_i | input | 1 | Execute reports that the running instruction changes the PC |
| q_en_o | output | 4 | Phase enables, bit 0 = Q1 through bit 3 = Q4 |
| pc_inc_o | output | 1 | Program counter advance enable (Q1) |
| ir_load_o | output | 1 | Instruction register load enable (Q4) |
| exec_valid_o | output | 1 | Word on `exec_word_o` is a real instruction to execute |
| exec_word_o | output | IW (16) | Word being executed, or the no-operation word |
| flush_o | output | 1 | Current instruction cycle executes a discarded prefetch |

## Verification
The phase enables, `pc_inc_o` and `ir_load_o` follow the phase register, so they change one clock edge after each phase step. A word on `instr_i` at the Q4 edge shows on `exec_word_o` in the very next period. A `pc_chg_i` sampled at a Q4 edge raises `flush_o` in the next period and holds it for four periods. Reset release lags `rst_n_i` by two edges. A reference model in the bench advances on each rising edge with these latencies, sampling the same inputs the design sees, and pushes one expected item per edge into a queue. A monitor pops each item at the following falling edge and compares every output field, so each result is checked in exactly the period it is due.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

  localparam int unsigned NUM_PHASES = 4;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

endpackage

// File: rtl/qseq_rst_sync.sv
module qseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_sync_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/qseq_phase_gen.sv
module qseq_phase_gen
  import qseq_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_n_i,
  output logic [NUM_PHASES-1:0] q_en_o
);

  phase_e ph_q;
  phase_e ph_d;

  always_comb begin
    ph_d = phase_e'(ph_q + 2'd1);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ph_q <= PH_Q1;
    end else begin
      ph_q <= ph_d;
    end
  end

  for (genvar gi = 0; gi < NUM_PHASES; gi++) begin : g_en
    assign q_en_o[gi] = rst_n_i & (ph_q == phase_e'(gi));
  end

  AST_ONE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $countones(q_en_o) == 1); // R3

  AST_Q4_WRAPS_TO_Q1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    q_en_o[3] |=> q_en_o[0]); // R3

endmodule

// File: rtl/qseq_fetch_ctl.sv
module qseq_fetch_ctl #(
  parameter int unsigned IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          q1_i,
  input  logic          q4_i,
  input  logic [IW-1:0] instr_i,
  output logic          pc_inc_o,
  output logic          ir_load_o,
  output logic [IW-1:0] ir_o,
  output logic          filled_o
);

  logic [IW-1:0] ir_q;
  logic [IW-1:0] ir_d;
  logic          filled_q;
  logic          filled_d;

  assign pc_inc_o  = q1_i;
  assign ir_load_o = q4_i;

  always_comb begin
    ir_d     = ir_q;
    filled_d = filled_q;
    if (ir_load_o) begin
      ir_d     = instr_i;
      filled_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ir_q     <= '0;
      filled_q <= 1'b0;
    end else begin
      ir_q     <= ir_d;
      filled_q <= filled_d;
    end
  end

  assign ir_o     = ir_q;
  assign filled_o = filled_q;

  AST_IR_HOLDS_OUTSIDE_Q4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !ir_load_o |=> $stable(ir_q)); // R5

  AST_PC_INC_THEN_Q2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    pc_inc_o |=> !pc_inc_o); // R4

endmodule

// File: rtl/qseq_exec_ctl.sv
module qseq_exec_ctl #(
  parameter int unsigned   IW       = 16,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          q1_i,
  input  logic          q4_i,
  input  logic          pc_chg_i,
  input  logic          ir_load_i,
  input  logic          filled_i,
  input  logic [IW-1:0] ir_i,
  output logic          exec_valid_o,
  output logic [IW-1:0] exec_word_o,
  output logic          flush_o
);

  logic flush_q;
  logic flush_d;
  logic redirect;

  assign exec_valid_o = filled_i & ~flush_q;
  assign redirect     = q4_i & pc_chg_i & exec_valid_o;

  always_comb begin
    flush_d = flush_q;
    if (q4_i) begin
      flush_d = redirect;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      flush_q <= 1'b0;
    end else begin
      flush_q <= flush_d;
    end
  end

  assign exec_word_o = exec_valid_o ? ir_i : NOP_WORD;
  assign flush_o     = flush_q;

  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (flush_q && q4_i) |=> !flush_q); // R8

  AST_FLUSH_STARTS_AT_Q1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(flush_q) |-> q1_i); // R8

  AST_VALID_AFTER_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(exec_valid_o) |-> $past(ir_load_i)); // R7

endmodule

// File: rtl/qseq_top.sv
module qseq_top
  import qseq_pkg::*;
#(
  parameter int unsigned   IW          = 16,
  parameter int unsigned   SYNC_STAGES = 2,
  parameter logic [IW-1:0] NOP_WORD    = '0
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic [IW-1:0] instr_i,
  input  logic          pc_chg_i,
  output logic [3:0]    q_en_o,
  output logic          pc_inc_o,
  output logic          ir_load_o,
  output logic          exec_valid_o,
  output logic [IW-1:0] exec_word_o,
  output logic          flush_o
);

  logic                  rst_int_n;
  logic [NUM_PHASES-1:0] q_en;
  logic [IW-1:0]         ir;
  logic                  filled;

  qseq_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .rst_sync_n_o (rst_int_n)
  );

  qseq_phase_gen u_phase (
    .clk_i   (clk_i),
    .rst_n_i (rst_int_n),
    .q_en_o  (q_en)
  );

  qseq_fetch_ctl #(
    .IW (IW)
  ) u_fetch (
    .clk_i     (clk_i),
    .rst_n_i   (rst_int_n),
    .q1_i      (q_en[PH_Q1]),
    .q4_i      (q_en[PH_Q4]),
    .instr_i   (instr_i),
    .pc_inc_o  (pc_inc_o),
    .ir_load_o (ir_load_o),
    .ir_o      (ir),
    .filled_o  (filled)
  );

  qseq_exec_ctl #(
    .IW       (IW),
    .NOP_WORD (NOP_WORD)
  ) u_exec (
    .clk_i        (clk_i),
    .rst_n_i      (rst_int_n),
    .q1_i         (q_en[PH_Q1]),
    .q4_i         (q_en[PH_Q4]),
    .pc_chg_i     (pc_chg_i),
    .ir_load_i    (ir_load_o),
    .filled_i     (filled),
    .ir_i         (ir),
    .exec_valid_o (exec_valid_o),
    .exec_word_o  (exec_word_o),
    .flush_o      (flush_o)
  );

  assign q_en_o = q_en;

  AST_PC_INC_IN_Q1_ONLY: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    pc_inc_o |=> q_en_o[1]); // R4

  AST_LOAD_BEFORE_Q1: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    ir_load_o |=> pc_inc_o); // R5

endmodule

// File: tb/sim_qseq_top.sv
module sim_qseq_top;

  typedef struct packed {
    logic [3:0]  q;
    logic        pc;
    logic        ld;
    logic        ev;
    logic        fl;
    logic [15:0] w;
    logic [3:0]  tq;
    logic [3:0]  tv;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [15:0] instr;
  logic        pc_chg;
  logic [3:0]  q_en;
  logic        pc_inc;
  logic        ir_load;
  logic        exec_valid;
  logic [15:0] exec_word;
  logic        flush;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  exp_t q_exp[$];

  int          m_sync, m_ph, m_ign, m_aft;
  bit          m_fill, m_fl, m_first;
  logic [15:0] m_ir;
  logic [15:0] word_ctr;

  qseq_top u0 (
    .clk_i        (clk),
    .rst_n_i      (rst_n),
    .instr_i      (instr),
    .pc_chg_i     (pc_chg),
    .q_en_o       (q_en),
    .pc_inc_o     (pc_inc),
    .ir_load_o    (ir_load),
    .exec_valid_o (exec_valid),
    .exec_word_o  (exec_word),
    .flush_o      (flush)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic string tname(logic [3:0] c);
    case (c)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      4'd10:   return "R10";
      default: return "R?";
    endcase
  endfunction

  // reference model: one expectation per rising edge
  always @(posedge clk) begin
    exp_t e;
    bit   act;
    if (!rst_n) begin
      m_sync = 0; m_ph = 0; m_fill = 0; m_fl = 0; m_ir = '0;
      m_ign = 0; m_aft = 0; m_first = 0;
    end else if (m_sync < 2) begin
      m_sync  = m_sync + 1;
      m_first = (m_sync == 2);
    end else begin
      m_first = 0;
      if (pc_chg && !(m_ph == 3 && m_fill && !m_fl)) m_ign = 4;
      else if (m_ign > 0) m_ign = m_ign - 1;
      if (m_ph == 3) begin
        bit nf;
        nf     = m_fill && !m_fl && pc_chg;
        m_aft  = m_fl ? 1 : 0;
        m_fl   = nf;
        m_ir   = instr;
        m_fill = 1;
      end
      m_ph = (m_ph + 1) % 4;
    end
    act  = (m_sync == 2);
    e.q  = act ? 4'(1 << m_ph) : 4'b0000;
    e.pc = act && (m_ph == 0);
    e.ld = act && (m_ph == 3);
    e.ev = m_fill && !m_fl;
    e.fl = m_fl;
    e.w  = e.ev ? m_ir : 16'h0000;
    if (!act)           begin e.tq = 4'd1; e.tv = 4'd1; end
    else begin
      e.tq = m_first ? 4'd2 : 4'd3;
      if (!m_fill)      e.tv = 4'd7;
      else if (m_fl)    e.tv = 4'd8;
      else if (m_aft>0) e.tv = 4'd10;
      else if (m_ign>0) e.tv = 4'd9;
      else              e.tv = 4'd6;
    end
    q_exp.push_back(e);
  end

  task automatic chk(string tag, string what, logic [15:0] a, logic [15:0] x);
    checks++;
    if (a !== x) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, a, x, $time);
    end
  endtask

  // monitor: compare at falling edge
  always @(negedge clk) begin
    if (q_exp.size() > 0 && !done) begin
      exp_t e;
      e = q_exp.pop_front();
      chk(tname(e.tq), "q_en", {12'd0, q_en}, {12'd0, e.q});
      chk(e.tq == 4'd1 ? "R1" : "R4", "pc_inc", {15'd0, pc_inc}, {15'd0, e.pc});
      chk(e.tq == 4'd1 ? "R1" : "R5", "ir_load", {15'd0, ir_load}, {15'd0, e.ld});
      chk(tname(e.tv), "exec_valid", {15'd0, exec_valid}, {15'd0, e.ev});
      chk(tname(e.tv), "flush", {15'd0, flush}, {15'd0, e.fl});
      chk(tname(e.tv), "exec_word", exec_word, e.w);
    end
  end

  // driver: mode 0 none, 1 Q1..Q3 only, 2 every Q4, 3 always high
  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      word_ctr = word_ctr + 16'h0101;
      instr    = word_ctr;
      case (mode)
        1:       pc_chg = (m_sync == 2) && (m_ph != 3);
        2:       pc_chg = (m_sync == 2) && (m_ph == 3);
        3:       pc_chg = 1'b1;
        default: pc_chg = 1'b0;
      endcase
    end
  endtask

  task automatic pulse_q4();
    do @(negedge clk); while (!(m_sync == 2 && m_ph == 3));
    pc_chg = 1'b1;
    instr  = 16'hBEEF;
    @(negedge clk);
    pc_chg = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; pc_chg = 0; instr = 16'h0000; word_ctr = 16'h1000;
    run(5, 0);                 // R1: reset state
    rst_n = 1;                 // R2: release, R7: no valid before capture
    run(40, 0);                // R3 R4 R5 R6: steady pipeline
    pulse_q4();                // R8: single redirect, R10 afterwards
    run(20, 0);
    run(24, 1);                // R9: request outside Q4 ignored
    run(32, 2);                // R8 R9: back-to-back requests, alternate cycles flush
    run(8, 0);
    @(negedge clk); rst_n = 0; // R1: reset mid-run
    run(6, 3);
    rst_n = 1;
    run(24, 3);                // R7 R9: request before first capture ignored
    run(12, 0);
    pulse_q4();
    run(12, 0);
    finish_run();
  end

endmodule